// File: doc/BRIEF.md
# Serial A1 Hunting Byte Aligner

This block turns a serial bit stream, qualified by a bit-rate clock enable, into parallel words with a one-cycle word strobe. The first bit received ends up in the most significant position of the word. While disarmed, the block cuts words at a free-running phase. It keeps that boundary fixed no matter what the data contains.

An active-low out-of-frame input arms the block to hunt for the framing word 8'hF6. Only a falling edge of this input counts, and the frame-disable input must be low at that edge. A falling edge while frame-disable is high disarms the block. A pulse from a downstream frame detector also disarms it. While the block hunts, it emits no strobes and drives its valid flag low. When the last W received bits equal the framing word, the block emits that word at once and restarts its word phase there. From then on it stays armed and realigns to any further framing word until it is disarmed.

Top module: `serial_hunt_aligner`

## Requirements
- R1: While reset is high and on the first cycle after reset, word_out is 0, word_stb is 0 and word_valid is 1, which means the block is disarmed.
- R2: Bits are taken only on cycles with bit_en high. The earliest bit of a word lands in word_out[7] and the latest in word_out[0]. word_stb is never high unless bit_en was high on the previous cycle.
- R3: When the block is not hunting, word_stb pulses for one cycle after every 8th accepted bit since the last boundary. word_out then holds those 8 bits, and word_out changes only together with word_stb.
- R4: A high-to-low change of oof_n, seen between two bit_en samples, arms hunting if frm_dis is low at that sample. While hunting, word_valid is 0 and word_stb stays 0.
- R5: While hunting, the bit that completes 8'hF6 (11110110) in the window produces word_stb with word_out = 8'hF6 and word_valid = 1 in the same cycle. The next strobe follows exactly 8 bits later.
- R6: After a match, while the block is still armed, a framing word that arrives at any other phase realigns the boundary to its last bit.
- R7: A high cycle on frame_pulse disarms the block. From then on, a framing word at a different phase causes no realignment.
- R8: A high-to-low change of oof_n seen while frm_dis is high disarms the block, and word_valid returns to 1.
- R9: If an arming edge and frame_pulse occur in the same bit_en cycle, the arming edge takes priority and hunting starts.
- R10: Holding oof_n low does not re-arm the block once it has been disarmed. Only a new falling edge arms it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Bit-rate enable; one serial bit per high cycle |
| bit_in | input | 1 | Serial data bit |
| oof_n | input | 1 | Active-low out-of-frame request; falling edge acts |
| frm_dis | input | 1 | Makes an out-of-frame falling edge disarm instead of arm |
| frame_pulse | input | 1 | Frame found by downstream detector; disarms |
| word_out | output | 8 | Parallel word, earliest bit in MSB |
| word_stb | output | 1 | One-cycle word strobe |
| word_valid | output | 1 | Low while hunting |

## Verification
The bench builds the block with its default parameters: an 8-bit word and the framing pattern 8'hF6. With these values every bit phase fits in one short vector. The table arms the hunt with offsets of 0, 1, 3, 5, 6 and 7 bits between the arming edge and the framing word, so the boundary has to move by a different amount each time. The directed tests then place a framing word three bits off the current boundary. This shows the difference between the armed case, where the block realigns, and the disarmed case, where it keeps its phase. Further tests cover disarming through frame-disable and the two orderings of the controls.

// File: rtl/sha_pkg.sv
package sha_pkg;

    localparam int unsigned DEF_WORD_W = 8;
    localparam logic [7:0]  DEF_FRAME_WORD = 8'hF6;

    typedef enum logic [1:0] {
        ARM_OFF   = 2'd0,
        ARM_HUNT  = 2'd1,
        ARM_TRACK = 2'd2
    } arm_state_e;

    typedef struct packed {
        logic arm;
        logic disarm;
    } oof_evt_t;

    // Arming edge has priority over any disarm source, then a match.
    function automatic arm_state_e arm_next(
        input arm_state_e cur,
        input logic       arm,
        input logic       disarm,
        input logic       hit
    );
        arm_state_e nx;
        nx = cur;
        if (arm)
            nx = ARM_HUNT;
        else if (disarm)
            nx = ARM_OFF;
        else if (hit)
            nx = ARM_TRACK;
        return nx;
    endfunction

endpackage

// File: rtl/sha_window.sv
module sha_window #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         bit_en,
    input  logic         bit_in,
    output logic [W-1:0] win_next
);
    logic [W-1:0] win_q;

    assign win_next = {win_q[W-2:0], bit_in};

    always_ff @(posedge clk) begin
        if (rst)
            win_q <= '0;
        else if (bit_en)
            win_q <= win_next;
    end
endmodule

// File: rtl/sha_oof_edge.sv
module sha_oof_edge
    import sha_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     bit_en,
    input  logic     oof_n,
    input  logic     frm_dis,
    output oof_evt_t evt
);
    logic oof_q;
    logic fall;

    assign fall       = bit_en & oof_q & ~oof_n;
    assign evt.arm    = fall & ~frm_dis;
    assign evt.disarm = fall & frm_dis;

    always_ff @(posedge clk) begin
        if (rst)
            oof_q <= 1'b1;
        else if (bit_en)
            oof_q <= oof_n;
    end
endmodule

// File: rtl/sha_phase_ctrl.sv
module sha_phase_ctrl
    import sha_pkg::*;
#(
    parameter int unsigned W   = 8,
    parameter logic [W-1:0] PAT = 8'hF6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         bit_en,
    input  logic [W-1:0] win_next,
    input  oof_evt_t     evt,
    input  logic         frame_pulse,
    output logic [W-1:0] word_out,
    output logic         word_stb,
    output logic         word_valid
);
    localparam int unsigned CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    arm_state_e    st_q;
    arm_state_e    st_nx;
    logic [CW-1:0] cnt_q;
    logic          hit;
    logic          wrap;
    logic          emit;

    assign hit   = bit_en && (st_q != ARM_OFF) && (win_next == PAT);
    assign wrap  = bit_en && (cnt_q == LAST);
    assign st_nx = arm_next(st_q, evt.arm, evt.disarm | frame_pulse, hit);
    assign emit  = (hit || (wrap && st_q != ARM_HUNT)) && (st_nx != ARM_HUNT);

    assign word_valid = (st_q != ARM_HUNT);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ARM_OFF;
            cnt_q    <= '0;
            word_out <= '0;
            word_stb <= 1'b0;
        end else begin
            st_q     <= st_nx;
            word_stb <= emit;
            if (bit_en)
                cnt_q <= (hit || wrap) ? '0 : cnt_q + 1'b1;
            if (emit)
                word_out <= win_next;
        end
    end
endmodule

// File: rtl/serial_hunt_aligner.sv
module serial_hunt_aligner
    import sha_pkg::*;
#(
    parameter int unsigned W   = DEF_WORD_W,
    parameter logic [W-1:0] PAT = DEF_FRAME_WORD
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         bit_en,
    input  logic         bit_in,
    input  logic         oof_n,
    input  logic         frm_dis,
    input  logic         frame_pulse,
    output logic [W-1:0] word_out,
    output logic         word_stb,
    output logic         word_valid
);
    logic [W-1:0] win_next;
    oof_evt_t     evt;

    sha_window #(.W(W)) u_win (
        .clk      (clk),
        .rst      (rst),
        .bit_en   (bit_en),
        .bit_in   (bit_in),
        .win_next (win_next)
    );

    sha_oof_edge u_edge (
        .clk     (clk),
        .rst     (rst),
        .bit_en  (bit_en),
        .oof_n   (oof_n),
        .frm_dis (frm_dis),
        .evt     (evt)
    );

    sha_phase_ctrl #(.W(W), .PAT(PAT)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .bit_en      (bit_en),
        .win_next    (win_next),
        .evt         (evt),
        .frame_pulse (frame_pulse),
        .word_out    (word_out),
        .word_stb    (word_stb),
        .word_valid  (word_valid)
    );
endmodule

// File: rtl/serial_hunt_aligner_chk.sv
module serial_hunt_aligner_chk #(
    parameter int unsigned W   = 8,
    parameter logic [W-1:0] PAT = 8'hF6
) (
    input logic         clk,
    input logic         rst,
    input logic         bit_en,
    input logic         oof_n,
    input logic         frm_dis,
    input logic         frame_pulse,
    input logic [W-1:0] word_out,
    input logic         word_stb,
    input logic         word_valid
);
    p_stb_after_en_r2: assert property (@(posedge clk) disable iff (rst)
        word_stb |-> $past(bit_en));

    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !word_stb |-> $stable(word_out));

    p_stb_valid_r4: assert property (@(posedge clk) disable iff (rst)
        word_stb |-> word_valid);

    p_hunt_entry_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(word_valid) |-> ($past(bit_en) && !$past(oof_n) && !$past(frm_dis)));

    p_align_word_r5: assert property (@(posedge clk) disable iff (rst)
        ($rose(word_valid) && word_stb) |-> (word_out == PAT));

    p_fp_disarm_r7: assert property (@(posedge clk) disable iff (rst)
        (frame_pulse && oof_n) |=> word_valid);
endmodule

bind serial_hunt_aligner serial_hunt_aligner_chk #(.W(W), .PAT(PAT)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bit_en      (bit_en),
    .oof_n       (oof_n),
    .frm_dis     (frm_dis),
    .frame_pulse (frame_pulse),
    .word_out    (word_out),
    .word_stb    (word_stb),
    .word_valid  (word_valid)
);

// File: tb/serial_hunt_aligner_test.sv
module serial_hunt_aligner_test;
    localparam logic [7:0] A1 = 8'hF6;
    // {prefix length[2:0], prefix bits[7:0], data word[7:0]}
    localparam int NV = 6;
    localparam logic [18:0] VEC [NV] = '{
        {3'd0, 8'h00, 8'h3C},
        {3'd1, 8'h01, 8'h55},
        {3'd3, 8'h05, 8'hA5},
        {3'd5, 8'h0A, 8'h00},
        {3'd7, 8'h55, 8'hFF},
        {3'd6, 8'h24, 8'h81}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_en = 1'b0, bit_in = 1'b0, oof_n = 1'b1, frm_dis = 1'b0, frame_pulse = 1'b0;
    logic [7:0] word_out;
    logic word_stb, word_valid;
    int n_chk = 0, n_fail = 0;
    logic s_stb, s_val;
    logic [7:0] s_word;

    always #4 clk = ~clk;

    serial_hunt_aligner uut (
        .clk(clk), .rst(rst), .bit_en(bit_en), .bit_in(bit_in),
        .oof_n(oof_n), .frm_dis(frm_dis), .frame_pulse(frame_pulse),
        .word_out(word_out), .word_stb(word_stb), .word_valid(word_valid)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One bit per two cycles; bit_in toggles on the idle cycle (R2).
    task automatic send_bit(input logic b);
        @(negedge clk);
        bit_en = 1'b1;
        bit_in = b;
        @(negedge clk);
        s_stb  = word_stb;
        s_val  = word_valid;
        s_word = word_out;
        bit_en = 1'b0;
        bit_in = ~b;
    endtask

    // Sends n bits MSB first; expects a strobe with word exp only on the last.
    task automatic send_word(input logic [7:0] w, input int n, input logic [7:0] exp, input string req);
        for (int i = n - 1; i >= 0; i--) begin
            send_bit(w[i]);
            if (i > 0) chk(s_stb == 1'b0, req, s_stb, 0);
        end
        chk(s_stb == 1'b1 && s_word == exp, req, s_word, exp);
    endtask

    task automatic pulse_fp();
        @(negedge clk);
        frame_pulse = 1'b1;
        @(negedge clk);
        frame_pulse = 1'b0;
        @(negedge clk);
    endtask

    task automatic arm();
        oof_n = 1'b0;
        send_bit(1'b0);
        chk(s_val == 1'b0 && s_stb == 1'b0, "R4 arm", s_val, 0);
        oof_n = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] pb, dw;
        int p, cnt;
        repeat (3) @(negedge clk);
        chk(word_out == 8'h00 && word_stb == 1'b0 && word_valid == 1'b1, "R1 in reset", word_out, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(word_out == 8'h00 && word_stb == 1'b0 && word_valid == 1'b1, "R1 after reset", word_valid, 1);

        // R2/R3: disarmed, phase starts at zero after reset, MSB first.
        send_word(8'h3A, 8, 8'h3A, "R2 bit order");
        send_word(8'hC5, 8, 8'hC5, "R3 free-running word");

        // Table: arm, offset prefix, framing word, data, disarm by frame pulse.
        for (int v = 0; v < NV; v++) begin
            p  = int'(VEC[v][18:16]);
            pb = VEC[v][15:8];
            dw = VEC[v][7:0];
            for (int i = 0; i < 8; i++) send_bit(1'b0);
            arm();
            for (int i = p - 1; i >= 0; i--) begin
                send_bit(pb[i]);
                chk(s_stb == 1'b0 && s_val == 1'b0, "R4 hunt quiet", s_stb, 0);
            end
            for (int i = 7; i >= 0; i--) begin
                send_bit(A1[i]);
                if (i > 0) chk(s_stb == 1'b0 && s_val == 1'b0, "R4 hunt quiet", s_stb, 0);
            end
            chk(s_stb == 1'b1 && s_word == A1 && s_val == 1'b1, "R5 align", s_word, A1);
            send_word(dw, 8, dw, "R5 phase restart");
            pulse_fp();
            chk(word_valid == 1'b1, "R7 fp disarm", word_valid, 1);
        end

        // R6: armed and tracking, framing word three bits off realigns.
        for (int i = 0; i < 8; i++) send_bit(1'b0);
        arm();
        send_word(A1, 8, A1, "R6 initial align");
        send_word({3'b010, A1[7:3]}, 8, 8'h5E, "R6 old phase");
        send_word({5'b0, A1[2:0]}, 3, A1, "R6 realign");
        send_word(8'h99, 8, 8'h99, "R6 new phase");
        pulse_fp();

        // R7: disarmed, same misaligned framing word leaves the phase alone.
        send_word({3'b010, A1[7:3]}, 8, 8'h5E, "R7 no realign");
        send_bit(A1[2]);
        send_bit(A1[1]);
        send_bit(A1[0]);
        chk(s_stb == 1'b0, "R7 no strobe at pattern end", s_stb, 0);
        send_word(8'h00, 5, 8'hC0, "R7 kept phase");

        // R8: falling edge with frame-disable high disarms the hunt.
        arm();
        send_bit(1'b0);
        frm_dis = 1'b1;
        oof_n = 1'b0;
        send_bit(1'b0);
        chk(s_val == 1'b1, "R8 disarm via frm_dis", s_val, 1);
        oof_n = 1'b1;
        frm_dis = 1'b0;
        cnt = 0;
        for (int i = 0; i < 16; i++) begin
            send_bit(1'b0);
            if (s_stb) cnt++;
        end
        chk(cnt == 2, "R8 R3 free-running after disarm", cnt, 2);

        // R9: arming edge and frame pulse in the same bit cycle.
        @(negedge clk);
        oof_n = 1'b0;
        frame_pulse = 1'b1;
        bit_en = 1'b1;
        bit_in = 1'b0;
        @(negedge clk);
        chk(word_valid == 1'b0, "R9 arm wins", word_valid, 0);
        frame_pulse = 1'b0;
        bit_en = 1'b0;

        // R10: oof_n held low, disarm by frame pulse, no re-arm on the level.
        pulse_fp();
        chk(word_valid == 1'b1, "R10 disarmed", word_valid, 1);
        cnt = 0;
        for (int i = 0; i < 8; i++) begin
            send_bit(1'b0);
            if (!s_val) cnt++;
        end
        chk(cnt == 0, "R10 level does not arm", cnt, 0);
        oof_n = 1'b1;
        send_bit(1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule